// File: doc/BRIEF.md
# SPI Serial SRAM Slave

This block is a serial static memory that answers as an SPI mode-0 slave. A host drops chip select, clocks in an 8-bit instruction most significant bit first, and then either streams data bytes into or out of a byte-addressed array, or reads or writes an 8-bit status register. The top two bits of that register choose how the internal address moves between data bytes: one byte per selection, a free-running sequence over the whole array, or a loop inside a 32-byte page.

All SPI pins are sampled by a system clock `clk` that runs much faster than the serial clock. The block finds serial clock edges from those samples. An active-low pause input can freeze a transfer at any bit boundary. It takes effect and releases only while the serial clock is low. While paused, the output is released and serial clock and data activity is discarded, so a shared serial clock can carry other traffic. The array holds `2**ADDR_W` bytes, and a 16-bit address is sent with every data command. Only its low `ADDR_W` bits are used.

Top module: `spi_sram`

## Requirements
- R1: While `cs_n` is high, `miso_oe` is low and the transfer state is cleared, so the next low period of `cs_n` starts with a fresh instruction even if the previous one was cut off part way.
- R2: `mosi` is sampled on rising `sck` edges and `miso` changes only after falling `sck` edges. Every field is sent most significant bit first.
- R3: Instruction 0x03 (read) takes a 16-bit address and then returns array bytes. Instruction 0x02 (write) takes a 16-bit address and then stores bytes. Only the low `ADDR_W` address bits select the byte, so higher bits alias.
- R4: A written byte is stored on the rising edge of its eighth bit. It stays stored when `cs_n` rises straight after that edge.
- R5: In sequential mode (status bits 7:6 = 01), the address advances by one after each data byte and wraps from `2**ADDR_W-1` to 0.
- R6: The status register resets to 0x40. Instruction 0x05 shifts it out, and instruction 0x01 loads it from the next 8 bits.
- R7: In byte mode (status bits 7:6 = 00), only the first data byte of a read or write takes effect. Further clocks in that selection write nothing and leave `miso_oe` low.
- R8: In page mode (status bits 7:6 = 10), the address advances within its aligned 32-byte page, wrapping from the page's last byte to its first.
- R9: Any other instruction value is ignored. `miso_oe` stays low and no byte is written until `cs_n` rises.
- R10: The pause starts when `hold_n` is low while `sck` is low. If `sck` is high when `hold_n` falls, the pause starts once `sck` falls. The pause ends only when `hold_n` is high while `sck` is low.
- R11: During the pause, `sck` and `mosi` activity is ignored and the bit position, shift contents and command state are kept. The transfer then resumes at exactly the paused bit.
- R12: `hold_n` low forces `miso_oe` low at once, whatever the level of `sck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low transfer pause |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; low means high-impedance |

## Verification
Write-then-read runs compare every returned byte with a behavioural byte array that applies its own address rule for each mode. Runs that cross the top of the array, use aliased high address bits, cross a page edge, or run past the first byte in byte mode show whether the address step rule and the commit rule were applied. An unknown instruction is followed by a byte sequence that would form a valid write, which shows whether decoding really stops. Pauses are placed mid-byte in a read with `sck` low, and in a write with `sck` high, with noise clocked in while paused. This separates correct freezing from lost or extra bits, and checks the deferred start of a pause requested while `sck` is high.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_AHI,
    ST_ALO,
    ST_RDAT,
    ST_WDAT,
    ST_SOUT,
    ST_SIN,
    ST_IDLE
  } sram_state_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;

  localparam logic [1:0] MODE_BYTE = 2'b00;
  localparam logic [1:0] MODE_SEQ  = 2'b01;
  localparam logic [1:0] MODE_PAGE = 2'b10;

  localparam logic [7:0] STATUS_RST = 8'h40;

endpackage

// File: rtl/spi_sram_front.sv
module spi_sram_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic rise,
  output logic fall,
  output logic paused
);

  logic sck_q;
  logic paused_q;
  logic paused_d;

  always_comb begin
    paused_d = paused_q;
    if (cs_n) begin
      paused_d = 1'b0;
    end else if (!sck) begin
      paused_d = !hold_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      sck_q    <= sck;
      paused_q <= paused_d;
    end
  end

  assign rise   = !cs_n && !paused_q &&  sck && !sck_q;
  assign fall   = !cs_n && !paused_q && !sck &&  sck_q;
  assign paused = paused_q;

endmodule

// File: rtl/spi_sram_step.sv
module spi_sram_step #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] nxt
);
  import spi_sram_pkg::*;

  logic [ADDR_W-1:0] inc;
  assign inc = cur + 1'b1;

  generate
    if (PAGE_W < ADDR_W) begin : g_page
      always_comb begin
        nxt = inc;
        if (mode == MODE_PAGE) begin
          nxt = {cur[ADDR_W-1:PAGE_W], inc[PAGE_W-1:0]};
        end
      end
    end else begin : g_flat
      logic unused_mode;
      assign unused_mode = ^mode;
      assign nxt = inc;
    end
  endgenerate

endmodule

// File: rtl/spi_sram_array.sv
module spi_sram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/spi_sram.sv
module spi_sram #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic hold_n,
  output logic miso,
  output logic miso_oe
);
  import spi_sram_pkg::*;

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;

  logic rise;
  logic fall;
  logic hold_act;

  sram_state_t       state_q, state_d;
  logic [2:0]        bit_q, bit_d;
  logic [6:0]        sin_q, sin_d;
  logic [7:0]        sout_q, sout_d;
  logic              oe_q, oe_d;
  logic              is_rd_q, is_rd_d;
  logic [HI_W-1:0]   ahi_q, ahi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        stat_q, stat_d;

  logic [7:0]        byte_in;
  logic [ADDR_W-1:0] addr_nx;
  logic [7:0]        rdata;
  logic              we;

  spi_sram_front u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sck    (sck),
    .hold_n (hold_n),
    .rise   (rise),
    .fall   (fall),
    .paused (hold_act)
  );

  spi_sram_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .cur  (addr_q),
    .mode (stat_q[7:6]),
    .nxt  (addr_nx)
  );

  spi_sram_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk   (clk),
    .we    (we),
    .addr  (addr_q),
    .wdata (byte_in),
    .rdata (rdata)
  );

  assign byte_in = {sin_q, mosi};

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sin_d   = sin_q;
    sout_d  = sout_q;
    oe_d    = oe_q;
    is_rd_d = is_rd_q;
    ahi_d   = ahi_q;
    addr_d  = addr_q;
    stat_d  = stat_q;
    we      = 1'b0;
    if (cs_n) begin
      state_d = ST_CMD;
      bit_d   = 3'd0;
      oe_d    = 1'b0;
    end else if (rise) begin
      bit_d = bit_q + 3'd1;
      sin_d = {sin_q[5:0], mosi};
      if (bit_q == 3'd7) begin
        unique case (state_q)
          ST_CMD: begin
            unique case (byte_in)
              OP_READ:  begin state_d = ST_AHI; is_rd_d = 1'b1; end
              OP_WRITE: begin state_d = ST_AHI; is_rd_d = 1'b0; end
              OP_RDSR:  state_d = ST_SOUT;
              OP_WRSR:  state_d = ST_SIN;
              default:  state_d = ST_IDLE;
            endcase
          end
          ST_AHI: begin
            ahi_d   = byte_in[HI_W-1:0];
            state_d = ST_ALO;
          end
          ST_ALO: begin
            addr_d  = {ahi_q, byte_in};
            state_d = is_rd_q ? ST_RDAT : ST_WDAT;
          end
          ST_WDAT: begin
            we     = 1'b1;
            addr_d = addr_nx;
            if (stat_q[7:6] == MODE_BYTE) state_d = ST_IDLE;
          end
          ST_RDAT: begin
            addr_d = addr_nx;
            if (stat_q[7:6] == MODE_BYTE) begin
              state_d = ST_IDLE;
              oe_d    = 1'b0;
            end
          end
          ST_SOUT: begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
          end
          ST_SIN: begin
            stat_d  = byte_in;
            state_d = ST_IDLE;
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end else if (fall) begin
      if (bit_q == 3'd0 && (state_q == ST_RDAT || state_q == ST_SOUT)) begin
        sout_d = (state_q == ST_RDAT) ? rdata : stat_q;
        oe_d   = 1'b1;
      end else begin
        sout_d = {sout_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      bit_q   <= 3'd0;
      sin_q   <= 7'd0;
      sout_q  <= 8'd0;
      oe_q    <= 1'b0;
      is_rd_q <= 1'b0;
      ahi_q   <= '0;
      addr_q  <= '0;
      stat_q  <= STATUS_RST;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sin_q   <= sin_d;
      sout_q  <= sout_d;
      oe_q    <= oe_d;
      is_rd_q <= is_rd_d;
      ahi_q   <= ahi_d;
      addr_q  <= addr_d;
      stat_q  <= stat_d;
    end
  end

  assign miso    = sout_q[7];
  assign miso_oe = oe_q && !hold_act && hold_n && !cs_n;

endmodule

// File: rtl/spi_sram_chk.sv
module spi_sram_chk (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cs_n,
  input logic                      hold_n,
  input logic                      miso_oe,
  input logic                      hold_act,
  input logic                      rise,
  input logic [2:0]                bit_q,
  input spi_sram_pkg::sram_state_t state_q
);
  import spi_sram_pkg::*;

  // R1: deselected output is released
  p_cs_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso_oe);

  // R1: a deselected cycle leaves a fresh transfer state
  p_cs_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_q == 3'd0 && state_q == ST_CMD));

  // R2: each sampled rising edge advances the bit position by one
  p_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (bit_q == $past(bit_q) + 3'd1));

  // R9: an ignored selection never drives the output
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && $past(state_q) == ST_CMD) |-> !miso_oe);

  // R11: the paused state is frozen
  p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_n && $past(hold_act) && !$past(cs_n))
      |-> ($stable(bit_q) && $stable(state_q)));

  // R12: the pause input releases the output at once
  p_hold_hiz_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |-> !miso_oe);

endmodule

bind spi_sram spi_sram_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .hold_n   (hold_n),
  .miso_oe  (miso_oe),
  .hold_act (hold_act),
  .rise     (rise),
  .bit_q    (bit_q),
  .state_q  (state_q)
);

// File: tb/spi_sram_bench.sv
module spi_sram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int HALF       = 4;

  logic clk;
  logic rst_n;
  logic cs_n;
  logic sck;
  logic mosi;
  logic hold_n;
  logic miso;
  logic miso_oe;

  int checks;
  int fails;
  bit done;

  logic [7:0] ref_mem [DEPTH];
  logic [7:0] ref_stat;

  spi_sram #(.ADDR_W(ADDR_W), .PAGE_BYTES(32)) u_spi_sram (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sck     (sck),
    .mosi    (mosi),
    .hold_n  (hold_n),
    .miso    (miso),
    .miso_oe (miso_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // every clock: output released whenever deselected or paused (R1, R12)
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && (cs_n || !hold_n)) begin
      check(miso_oe == 1'b0, "R1/R12 per-clock release", int'(miso_oe), 0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r, output logic oe);
    mosi = b;
    wait_clk(HALF);
    r  = miso;
    oe = miso_oe;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    logic r, oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r, oe);
      rx[i] = r;
      oe_all = oe_all & oe;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  function automatic int step(input int a);
    if (ref_stat[7:6] == 2'b10) return (a & ~31) | ((a + 1) & 31);
    return (a + 1) % DEPTH;
  endfunction

  task automatic send_hdr(input logic [7:0] op, input int a16);
    logic [7:0] rx;
    logic oe;
    byte_x(op, rx, oe);
    byte_x(a16[15:8], rx, oe);
    byte_x(a16[7:0], rx, oe);
  endtask

  task automatic do_write(input int a16, input logic [7:0] q[$]);
    logic [7:0] rx;
    logic oe;
    int a;
    a = a16 % DEPTH;
    sel();
    send_hdr(8'h02, a16);
    for (int k = 0; k < q.size(); k++) begin
      byte_x(q[k], rx, oe);
      if (!(ref_stat[7:6] == 2'b00 && k > 0)) begin
        ref_mem[a] = q[k];
        a = step(a);
      end
    end
    desel();
  endtask

  task automatic do_read(input int a16, input int n, input string req);
    logic [7:0] rx;
    logic oe;
    int a;
    a = a16 % DEPTH;
    sel();
    send_hdr(8'h03, a16);
    for (int k = 0; k < n; k++) begin
      byte_x(8'h00, rx, oe);
      if (ref_stat[7:6] == 2'b00 && k > 0) begin
        check(oe == 1'b0, {req, " R7 byte mode stays released"}, int'(oe), 0);
      end else begin
        check(oe == 1'b1, {req, " read drives output"}, int'(oe), 1);
        check(rx == ref_mem[a], {req, " read data"}, int'(rx), int'(ref_mem[a]));
        a = step(a);
      end
    end
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] rx;
    logic oe;
    sel();
    byte_x(8'h01, rx, oe);
    byte_x(v, rx, oe);
    desel();
    ref_stat = v;
  endtask

  task automatic rdsr_check(input string req);
    logic [7:0] rx;
    logic oe;
    sel();
    byte_x(8'h05, rx, oe);
    byte_x(8'h00, rx, oe);
    desel();
    check(oe == 1'b1, {req, " status drives output"}, int'(oe), 1);
    check(rx == ref_stat, {req, " status value"}, int'(rx), int'(ref_stat));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, rx2, tx;
    logic r, oe, oe_all;
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    cs_n   = 1'b1;
    sck    = 1'b0;
    mosi   = 1'b0;
    hold_n = 1'b1;
    ref_stat = 8'h40;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // reset state
    check(miso_oe == 1'b0, "R1 reset output released", int'(miso_oe), 0);
    rdsr_check("R6 reset status");

    // aborted instruction, then a fresh one (R1)
    sel();
    for (int i = 0; i < 4; i++) bit_x(1'b1, r, oe);
    desel();
    rdsr_check("R1 fresh instruction after abort");

    // sequential write and read, MSB first (R2, R3, R4, R5)
    do_write(16'h0010, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h81});
    do_read(16'h0010, 5, "R2 R3 R4 R5 sequential");

    // wrap at the top of the array (R5)
    do_write(DEPTH - 2, '{8'hA1, 8'hA2, 8'hA3});
    do_read(DEPTH - 2, 3, "R5 wrap");

    // high address bits alias (R3)
    do_write(16'h8005 | DEPTH, '{8'h5A});
    do_read(16'h0005, 1, "R3 alias");

    // byte mode (R7)
    do_write(16'h0200, '{8'h01, 8'h02});
    wrsr(8'h00);
    rdsr_check("R6 status load byte");
    do_write(16'h0200, '{8'hF0, 8'hF1});
    do_read(16'h0200, 2, "R7 byte mode");
    wrsr(8'h40);
    do_read(16'h0200, 2, "R7 second byte untouched");

    // page mode (R8)
    do_write(16'h0040, '{8'hC0});
    wrsr(8'h80);
    rdsr_check("R6 status load page");
    do_write(16'h003E, '{8'hB0, 8'hB1, 8'hB2});
    wrsr(8'h40);
    do_read(16'h003E, 3, "R8 page wrap");
    do_read(16'h0020, 1, "R8 page start");

    // unknown instruction (R9)
    sel();
    byte_x(8'hFF, rx, oe_all);
    byte_x(8'h02, rx, oe_all);
    check(oe_all == 1'b0, "R9 unknown opcode released", int'(oe_all), 0);
    byte_x(8'h00, rx, oe_all);
    byte_x(8'h20, rx, oe_all);
    byte_x(8'hEE, rx, oe_all);
    check(oe_all == 1'b0, "R9 unknown opcode later bytes", int'(oe_all), 0);
    desel();
    do_read(16'h0020, 1, "R9 no write after unknown");

    // pause during a read with sck low (R10, R11, R12)
    sel();
    send_hdr(8'h03, 16'h0010);
    rx = 8'h00;
    for (int i = 7; i >= 5; i--) begin
      bit_x(1'b0, r, oe);
      rx[i] = r;
    end
    hold_n = 1'b0;
    wait_clk(1);
    check(miso_oe == 1'b0, "R12 pause releases at once", int'(miso_oe), 0);
    for (int i = 0; i < 3; i++) begin
      mosi = ~mosi;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
    end
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 4; i >= 0; i--) begin
      bit_x(1'b0, r, oe);
      rx[i] = r;
    end
    check(rx == ref_mem[16'h0010], "R11 resumed read byte", int'(rx), int'(ref_mem[16'h0010]));
    byte_x(8'h00, rx2, oe);
    check(rx2 == ref_mem[16'h0011], "R11 next byte after pause", int'(rx2), int'(ref_mem[16'h0011]));
    desel();

    // pause requested with sck high during a write (R10, R11, R12)
    tx = 8'hD5;
    sel();
    send_hdr(8'h02, 16'h0060);
    for (int i = 7; i >= 4; i--) bit_x(tx[i], r, oe);
    mosi = tx[3];
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(2);
    hold_n = 1'b0;
    wait_clk(1);
    check(miso_oe == 1'b0, "R12 pause with sck high", int'(miso_oe), 0);
    wait_clk(1);
    sck = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 2; i++) begin
      mosi = ~mosi;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
    end
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 2; i >= 0; i--) bit_x(tx[i], r, oe);
    desel();
    ref_mem[16'h0060] = tx;
    do_read(16'h0060, 1, "R10 deferred pause write");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule